// File: doc/BRIEF.md
# Command Packet Receiver with Group Addressing

This block watches a narrow command bus made of one frame-start line and a ten-bit command word, and decides whether each request on it is meant for the local device. A request spans four consecutive words. The frame-start line marks the first word and stays low on the other three. The first word carries a nine-bit target identifier and the top command bit. The other words carry the remaining command bits, the bank, the row and the column. The bus captures data on both clock edges, but here that is modelled as one word per clock.

The receiver assembles the four words into a 40-bit request and compares the identifier with the device's own 8-bit identifier. It supports group addressing: when the top identifier bit is set, the low-order bits are ignored up to and including the lowest zero bit, so one request can reach an aligned power-of-two group of devices or every device at once. An addressed request gives a one-cycle pulse, and its decoded fields are held until the next addressed request. Data movement and register access are handled elsewhere.

Top module: `cmd_pkt_rx`

## Requirements
- R1: While and after reset, before any addressed request, `hit_o` and all decoded outputs are 0.
- R2: A request is a word sampled with `flag_i`=1, followed by three words sampled with `flag_i`=0. On an addressed request, `hit_o` is high for exactly one cycle, in the cycle after the edge that samples the fourth word.
- R3: Word 1 carries identifier bit 8 in `ca_i[9]` and identifier bits 7..0 in `ca_i[8:1]`. When identifier bit 8 is 0, the request is addressed only if identifier bits 7..0 equal `dev_id_i`.
- R4: When identifier bit 8 is 1, every identifier bit from bit 0 up to and including the lowest 0 bit is ignored, and the bits above it must equal `dev_id_i`. An identifier of all ones addresses every device.
- R5: A request whose identifier does not match gives no pulse and leaves every decoded output unchanged.
- R6: Command bit 5 is `ca_i[0]` of word 1; command bits 4..0 are `ca_i[9:5]` of word 2. When command bit 5 is 0, `rw_o`=1, `act_o`=bit 4, `burst8_o`=bit 3, `wr_o`=bit 2, `close_o`=bit 1 and `dclk_o`=bit 0.
- R7: When command bit 5 is 1, `rw_o`=0 and `act_o`, `burst8_o`, `wr_o`, `close_o` and `dclk_o` are all 0.
- R8: Bank is `ca_i[4:2]` of word 2. Row bits 10..9 are `ca_i[1:0]` of word 2 and row bits 8..0 are `ca_i[9:1]` of word 3. Column is `ca_i[6:0]` of word 4. The other bits of words 3 and 4 are ignored.
- R9: If `flag_i` is 1 on the second, third or fourth word, the partial request is dropped and that word is taken as a new first word.
- R10: Words sampled with `flag_i`=0 while no request is being assembled are ignored.
- R11: A new first word may arrive on the cycle right after a fourth word and is accepted.
- R12: Decoded outputs change only in the cycle that `hit_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus word per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | 1 | Frame start, high on the first word of a request |
| ca_i | input | 10 | Command/address word |
| dev_id_i | input | 8 | Identifier of this device, static after reset |
| hit_o | output | 1 | One-cycle pulse for an addressed request |
| rw_o | output | 1 | Request is a read/write (command bit 5 was 0) |
| act_o | output | 1 | Open the row before the access |
| burst8_o | output | 1 | 8-word burst (1) or 4-word burst (0) |
| wr_o | output | 1 | Write (1) or read (0) |
| close_o | output | 1 | Close the row after the access |
| dclk_o | output | 1 | Data clock pair select |
| bank_o | output | 3 | Decoded bank |
| row_o | output | 11 | Decoded row |
| col_o | output | 7 | Decoded column |

## Verification
Each result is due one clock after the rising edge that samples the fourth word. The pulse and every decoded field become visible together and then hold. The bench changes inputs on the falling edge. On every falling edge it compares all outputs with a behavioural model that was updated with the previous cycle's inputs, so each comparison looks exactly one edge after the word that caused it. Per-scenario pulse counts are checked after one idle trailing cycle, so the last pulse of a scenario is always counted.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;
   localparam int unsigned PKT_WORD_W = 10;
   localparam int unsigned PKT_WORDS  = 4;
   localparam int unsigned PKT_ID_W   = 8;
   localparam int unsigned PKT_CMD_W  = 6;
   localparam int unsigned PKT_BANK_W = 3;
   localparam int unsigned PKT_ROW_W  = 11;
   localparam int unsigned PKT_COL_W  = 7;

   typedef struct packed {
      logic                  rw;
      logic                  act;
      logic                  burst8;
      logic                  wr;
      logic                  close;
      logic                  dclk;
      logic [PKT_BANK_W-1:0] bank;
      logic [PKT_ROW_W-1:0]  row;
      logic [PKT_COL_W-1:0]  col;
   } req_fields_t;
endpackage

// File: rtl/pkt_assembler.sv
module pkt_assembler #(
   parameter int unsigned WORD_W  = 10,
   parameter int unsigned N_WORDS = 4,
   localparam int unsigned PKT_W  = WORD_W * N_WORDS,
   localparam int unsigned HOLD_W = WORD_W * (N_WORDS - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              done_o,
   output logic [PKT_W-1:0]  pkt_o
);
   localparam int unsigned CNT_W = $clog2(N_WORDS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_WORDS - 1);

   logic [HOLD_W-1:0] held_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;

   always_comb begin
      done_o = busy_q && !flag_i && (cnt_q == LAST);
      pkt_o  = {held_q, word_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (flag_i) begin
         held_q <= {held_q[HOLD_W-WORD_W-1:0], word_i};
         cnt_q  <= CNT_W'(1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
         end else begin
            held_q <= {held_q[HOLD_W-WORD_W-1:0], word_i};
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/id_matcher.sv
module id_matcher #(
   parameter int unsigned ID_W        = 8,
   parameter bit          GROUP_MATCH = 1'b1
) (
   input  logic            grp_i,
   input  logic [ID_W-1:0] pid_i,
   input  logic [ID_W-1:0] dev_i,
   output logic            match_o
);
   logic [ID_W-1:0] care;

   generate
      if (GROUP_MATCH) begin : g_group
         logic [ID_W:0] zero_below;
         assign zero_below[0] = 1'b0;
         for (genvar i = 0; i < ID_W; i++) begin : g_bit
            assign zero_below[i+1] = zero_below[i] | ~pid_i[i];
            assign care[i]         = ~grp_i | zero_below[i];
         end
         logic chain_unused;
         assign chain_unused = zero_below[ID_W];
      end else begin : g_exact
         logic grp_unused;
         assign grp_unused = grp_i;
         assign care       = '1;
      end
   endgenerate

   assign match_o = ~|((pid_i ^ dev_i) & care);
endmodule

// File: rtl/rw_decoder.sv
module rw_decoder
   import cmd_pkt_pkg::*;
(
   input  logic [PKT_CMD_W-1:0]  cmd_i,
   input  logic [PKT_BANK_W-1:0] bank_i,
   input  logic [PKT_ROW_W-1:0]  row_i,
   input  logic [PKT_COL_W-1:0]  col_i,
   output req_fields_t           fld_o
);
   logic xfer;

   always_comb begin
      xfer          = ~cmd_i[5];
      fld_o.rw      = xfer;
      fld_o.act     = xfer & cmd_i[4];
      fld_o.burst8  = xfer & cmd_i[3];
      fld_o.wr      = xfer & cmd_i[2];
      fld_o.close   = xfer & cmd_i[1];
      fld_o.dclk    = xfer & cmd_i[0];
      fld_o.bank    = bank_i;
      fld_o.row     = row_i;
      fld_o.col     = col_i;
   end
endmodule

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
   import cmd_pkt_pkg::*;
#(
   parameter int unsigned WORD_W      = PKT_WORD_W,
   parameter int unsigned N_WORDS     = PKT_WORDS,
   parameter int unsigned ID_W        = PKT_ID_W,
   parameter int unsigned BANK_W      = PKT_BANK_W,
   parameter int unsigned ROW_W       = PKT_ROW_W,
   parameter int unsigned COL_W       = PKT_COL_W,
   parameter bit          GROUP_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_i,
   input  logic [WORD_W-1:0] ca_i,
   input  logic [ID_W-1:0]   dev_id_i,
   output logic              hit_o,
   output logic              rw_o,
   output logic              act_o,
   output logic              burst8_o,
   output logic              wr_o,
   output logic              close_o,
   output logic              dclk_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [COL_W-1:0]  col_o
);
   localparam int unsigned PKT_W    = WORD_W * N_WORDS;
   localparam int unsigned GRP_POS  = PKT_W - 1;
   localparam int unsigned ID_LO    = GRP_POS - ID_W;
   localparam int unsigned CMD_HI   = ID_LO - 1;
   localparam int unsigned CMD_LO   = CMD_HI - PKT_CMD_W + 1;
   localparam int unsigned BANK_LO  = CMD_LO - BANK_W;
   localparam int unsigned ROW_LO   = BANK_LO - ROW_W;
   localparam int unsigned SPARE_HI = ROW_LO - 1;
   localparam int unsigned SPARE_LO = COL_W;

   generate
      if (WORD_W != PKT_WORD_W || N_WORDS != PKT_WORDS) begin : g_bad_frame
         $error("cmd_pkt_rx: frame must be %0d words of %0d bits", PKT_WORDS, PKT_WORD_W);
      end
      if (ID_W != PKT_ID_W || BANK_W != PKT_BANK_W) begin : g_bad_id
         $error("cmd_pkt_rx: identifier or bank width does not fit the frame");
      end
      if (ROW_W != PKT_ROW_W || COL_W != PKT_COL_W) begin : g_bad_addr
         $error("cmd_pkt_rx: row or column width does not fit the frame");
      end
      if (SPARE_HI < SPARE_LO) begin : g_bad_spare
         $error("cmd_pkt_rx: fields overlap inside the frame");
      end
   endgenerate

   logic             done;
   logic [PKT_W-1:0] pkt;
   logic             match;
   req_fields_t      dec;
   req_fields_t      fld_q;
   logic             hit_q;
   logic             spare_unused;

   pkt_assembler #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_asm (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flag_i),
      .word_i (ca_i),
      .done_o (done),
      .pkt_o  (pkt)
   );

   id_matcher #(.ID_W(ID_W), .GROUP_MATCH(GROUP_MATCH)) u_match (
      .grp_i   (pkt[GRP_POS]),
      .pid_i   (pkt[GRP_POS-1:ID_LO]),
      .dev_i   (dev_id_i),
      .match_o (match)
   );

   rw_decoder u_dec (
      .cmd_i  (pkt[CMD_HI:CMD_LO]),
      .bank_i (pkt[CMD_LO-1:BANK_LO]),
      .row_i  (pkt[BANK_LO-1:ROW_LO]),
      .col_i  (pkt[COL_W-1:0]),
      .fld_o  (dec)
   );

   assign spare_unused = ^pkt[SPARE_HI:SPARE_LO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         fld_q <= '0;
      end else begin
         hit_q <= done & match;
         if (done && match) begin
            fld_q <= dec;
         end
      end
   end

   assign hit_o    = hit_q;
   assign rw_o     = fld_q.rw;
   assign act_o    = fld_q.act;
   assign burst8_o = fld_q.burst8;
   assign wr_o     = fld_q.wr;
   assign close_o  = fld_q.close;
   assign dclk_o   = fld_q.dclk;
   assign bank_o   = fld_q.bank;
   assign row_o    = fld_q.row;
   assign col_o    = fld_q.col;
endmodule

// File: rtl/cmd_pkt_rx_chk.sv
module cmd_pkt_rx_chk #(
   parameter int unsigned WORD_W = 10,
   parameter int unsigned ID_W   = 8,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned ROW_W  = 11,
   parameter int unsigned COL_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flag_i,
   input logic [WORD_W-1:0] ca_i,
   input logic [ID_W-1:0]   dev_id_i,
   input logic              hit_o,
   input logic              rw_o,
   input logic              act_o,
   input logic              burst8_o,
   input logic              wr_o,
   input logic              close_o,
   input logic              dclk_o,
   input logic [BANK_W-1:0] bank_o,
   input logic [ROW_W-1:0]  row_o,
   input logic [COL_W-1:0]  col_o
);
   // R2
   hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

   // R2 R9
   hit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ($past(flag_i, 4) && !$past(flag_i, 3) && !$past(flag_i, 2) && !$past(flag_i, 1)));

   // R3
   exact_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && !$past(ca_i[WORD_W-1], 4)) |-> ($past(ca_i[WORD_W-2:1], 4) == dev_id_i));

   // R6
   kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (rw_o == !$past(ca_i[0], 4)));

   // R7
   maint_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_o |-> !(act_o | burst8_o | wr_o | close_o | dclk_o));

   // R12
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> ($stable(bank_o) && $stable(row_o) && $stable(col_o) && $stable(rw_o)
                  && $stable(act_o) && $stable(wr_o)));
endmodule

bind cmd_pkt_rx cmd_pkt_rx_chk #(
   .WORD_W(WORD_W), .ID_W(ID_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/cmd_pkt_rx_tb.sv
`timescale 1ns/1ps
module cmd_pkt_rx_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        flag;
   logic [9:0]  ca;
   logic [7:0]  dev_id;
   logic        hit, rw, act, b8, wr, cl, dk;
   logic [2:0]  bank;
   logic [10:0] row;
   logic [6:0]  col;

   always #2.5 clk = ~clk;

   cmd_pkt_rx u_dut (
      .clk(clk), .rst_n(rst_n), .flag_i(flag), .ca_i(ca), .dev_id_i(dev_id),
      .hit_o(hit), .rw_o(rw), .act_o(act), .burst8_o(b8), .wr_o(wr),
      .close_o(cl), .dclk_o(dk), .bank_o(bank), .row_o(row), .col_o(col)
   );

   int    n_chk = 0;
   int    n_err = 0;
   int    hits  = 0;
   string cur_req = "R1";

   // behavioural model state
   int          mcnt = 0;
   logic [9:0]  mw [4];
   logic [27:0] exp_vec = '0;   // {hit, rw, act, b8, wr, cl, dk, bank, row, col}

   function automatic bit ref_match(logic [8:0] id, logic [7:0] dv);
      int b;
      if (!id[8]) return id[7:0] == dv;
      b = 0;
      while (b < 8 && id[b]) b++;
      for (int k = b + 1; k < 8; k++)
         if (id[k] != dv[k]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [27:0] dut_vec();
      return {hit, rw, act, b8, wr, cl, dk, bank, row, col};
   endfunction

   task automatic check(string req, logic [27:0] a, logic [27:0] e);
      n_chk++;
      if (a !== e) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, a, e);
      end
   endtask

   task automatic model_update(logic f, logic [9:0] w);
      logic [5:0] cmd;
      exp_vec[27] = 1'b0;
      if (f) begin
         mw[0] = w; mcnt = 1;
      end else if (mcnt > 0) begin
         mw[mcnt] = w; mcnt++;
         if (mcnt == 4) begin
            mcnt = 0;
            if (ref_match(mw[0][9:1], dev_id)) begin
               cmd = {mw[0][0], mw[1][9:5]};
               exp_vec[27] = 1'b1;
               exp_vec[26] = !cmd[5];
               exp_vec[25:21] = cmd[5] ? 5'b0 : cmd[4:0];
               exp_vec[20:18] = mw[1][4:2];
               exp_vec[17:7]  = {mw[1][1:0], mw[2][9:1]};
               exp_vec[6:0]   = mw[3][6:0];
            end
         end
      end
   endtask

   task automatic step(logic f, logic [9:0] w);
      @(negedge clk);
      if (hit === 1'b1) hits++;
      check(cur_req, dut_vec(), exp_vec);
      flag = f; ca = w;
      model_update(f, w);
   endtask

   task automatic send_pkt(logic [8:0] id, logic [5:0] cmd, logic [2:0] bk,
                           logic [10:0] rw_a, logic [6:0] cl_a);
      step(1'b1, {id, cmd[5]});
      step(1'b0, {cmd[4:0], bk, rw_a[10:9]});
      step(1'b0, {rw_a[8:0], 1'b1});
      step(1'b0, {3'b101, cl_a});
   endtask

   task automatic check_hits(string req, int e);
      step(1'b0, 10'h000);
      n_chk++;
      if (hits != e) begin
         n_err++;
         $display("FAIL %s hit count actual=%0d expected=%0d", req, hits, e);
      end
      hits = 0;
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flag = 1'b0; ca = 10'h3FF; dev_id = 8'hF5;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      check("R1", dut_vec(), '0);
      rst_n = 1'b1;

      cur_req = "R10";
      for (int i = 0; i < 5; i++) step(1'b0, 10'h3FF - 10'(i));
      check_hits("R10", 0);

      // R3 R6 R8: exact identifier, read/write decode, field positions
      cur_req = "R3";
      send_pkt({1'b0, 8'hF5}, 6'b011101, 3'd5, 11'h5A3, 7'h4C);
      check_hits("R3", 1);
      cur_req = "R6";
      check("R6", {act, b8, wr, cl, dk, rw}, 6'b111011);
      cur_req = "R8";
      check("R8", {bank, row, col}, {3'd5, 11'h5A3, 7'h4C});

      // R5: mismatching identifier leaves fields alone
      cur_req = "R5";
      send_pkt({1'b0, 8'hF4}, 6'b000000, 3'd1, 11'h001, 7'h01);
      check_hits("R5", 0);
      check("R5", {bank, row, col}, {3'd5, 11'h5A3, 7'h4C});

      // R4: group forms
      cur_req = "R4";
      send_pkt({1'b1, 8'b1111_0011}, 6'b000110, 3'd2, 11'h2F0, 7'h11);
      send_pkt({1'b1, 8'b1110_1011}, 6'b000001, 3'd3, 11'h0F0, 7'h22);
      send_pkt({1'b1, 8'b1111_0110}, 6'b000001, 3'd4, 11'h0AA, 7'h33);
      send_pkt({1'b1, 8'b1111_0101}, 6'b010001, 3'd6, 11'h155, 7'h44);
      send_pkt({1'b1, 8'hFF},       6'b001000, 3'd7, 11'h7FF, 7'h7F);
      check_hits("R4", 3);

      // R7: maintenance command
      cur_req = "R7";
      send_pkt({1'b0, 8'hF5}, 6'b111111, 3'd0, 11'h123, 7'h05);
      check_hits("R7", 1);
      check("R7", {rw, act, b8, wr, cl, dk, bank}, {7'b0, 3'd0});

      // R9: early frame start restarts assembly
      cur_req = "R9";
      step(1'b1, {9'h0F5, 1'b0});
      step(1'b0, 10'h3FF);
      send_pkt({1'b0, 8'hF5}, 6'b000100, 3'd1, 11'h0C3, 7'h3A);
      step(1'b1, {9'h0F5, 1'b0});
      step(1'b0, 10'h155);
      step(1'b0, 10'h2AA);
      send_pkt({1'b1, 8'hFF}, 6'b010000, 3'd2, 11'h444, 7'h0F);
      check_hits("R9", 2);

      // R11: back-to-back requests; R2 pulse width covered per cycle
      cur_req = "R11";
      send_pkt({1'b0, 8'hF5}, 6'b001010, 3'd3, 11'h111, 7'h12);
      send_pkt({1'b0, 8'hF5}, 6'b000101, 3'd4, 11'h222, 7'h34);
      send_pkt({1'b0, 8'hF5}, 6'b011000, 3'd6, 11'h333, 7'h56);
      check_hits("R11", 3);

      // R2 R12: mixed random traffic against the model
      cur_req = "R12";
      for (int i = 0; i < 400; i++) begin
         logic [9:0] w;
         w = 10'($urandom);
         if (($urandom % 5) == 0) w[9:1] = {1'b0, 8'hF5};
         step(($urandom % 4) == 0, w);
      end
      cur_req = "R2";
      for (int i = 0; i < 40; i++) begin
         send_pkt({1'($urandom), 8'($urandom | 8'hF0)}, 6'($urandom),
                  3'($urandom), 11'($urandom), 7'($urandom));
      end
      step(1'b0, 10'h000);
      step(1'b0, 10'h000);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule